// File: doc/BRIEF.md
# Character Display Command Decoder

This block sits between a host bus and the internal memories of a character dot-matrix display controller. The host presents a two-bit register select, a read/write bit, an 8-bit data byte and a write strobe. Address-set commands load one shared address counter. Each of them also makes one of three memories the sticky target: the character-code memory, the glyph pattern memory or the attribute memory. Data-write commands then go to that target through a one-cycle write port, and the counter steps up or down after each write.

Writes to the character-code memory are checked against the legal address windows of the current line mode. An illegal write is dropped and flagged. Every accepted command raises a busy flag that lasts a fixed number of oscillator ticks, and the block ignores any command that arrives while busy is high. The line-mode bit and the step direction come in as plain inputs. The memories, display scanning and panel drive live outside this block.

Top module: `chardisp_cmd_decoder`

## Requirements
- R1: After a synchronous reset, `addr_count` is 0, `target_sel` is 0 (character-code memory), `busy` is low and no write strobe or `addr_err` is asserted.
- R2: A write with `host_rs`=2'b10, `host_rw`=0 and data bit 7 set loads data bits 6:0 into the counter and sets `target_sel` to 0 (character-code memory).
- R3: A write with `host_rs`=2'b10, `host_rw`=0 and data bits 7:6 = 2'b01 loads data bits 5:0 into the counter, with bit 6 cleared, and sets `target_sel` to 1 (pattern memory).
- R4: A write with `host_rs`=2'b10, `host_rw`=0 and data bits 7:5 = 3'b001 loads data bits 4:0 into the counter, with bits 6:5 cleared, and sets `target_sel` to 2 (attribute memory).
- R5: A write with `host_rs`=2'b11 and `host_rw`=0 produces, one cycle after it is accepted, a single-cycle strobe on exactly one of `chr_we`, `pat_we` or `atr_we`. The strobe goes to the current target, with `mem_addr` equal to the counter before the step and `mem_data` equal to the written byte.
- R6: The target stays unchanged across any number of data writes, until another address-set command arrives.
- R7: After each data write the counter increments when `entry_inc` is 1 and decrements when it is 0.
- R8: Counter steps wrap modulo 64 while the pattern memory is the target and modulo 128 otherwise.
- R9: With `two_line`=0, character-code addresses 0x00 to 0x4F are legal. A data write to the character-code memory at any other address asserts `addr_err` for one cycle instead of `chr_we`, and the counter still steps.
- R10: With `two_line`=1, the legal character-code addresses are 0x00 to 0x27 and 0x40 to 0x67. Writes outside these windows behave as in R9.
- R11: `busy` rises one cycle after every accepted command. It falls after exactly `BUSY_TICKS` (default 10) `osc_tick` pulses have been sampled, not counting a pulse in the accept cycle.
- R12: A strobe that arrives while `busy` is high has no effect on strobes, the counter or the target.
- R13: Reads (`host_rw`=1), select values 2'b00 and 2'b01, and select 2'b10 with data bits 7:5 = 3'b000 are not accepted. They do not raise `busy`, change the counter or target, or strobe a memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| host_we | input | 1 | Host command strobe |
| host_rs | input | 2 | Register select |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_data | input | 8 | Command or data byte |
| entry_inc | input | 1 | Step direction: 1 = increment, 0 = decrement |
| two_line | input | 1 | Line mode: 0 = one line, 1 = two lines |
| busy | output | 1 | Command in execution |
| addr_count | output | 7 | Shared address counter |
| target_sel | output | 2 | Selected memory: 0 char, 1 pattern, 2 attribute |
| chr_we | output | 1 | Character-code memory write strobe |
| pat_we | output | 1 | Pattern memory write strobe |
| atr_we | output | 1 | Attribute memory write strobe |
| mem_addr | output | 7 | Write address for the strobed memory |
| mem_data | output | 8 | Write data for the strobed memory |
| addr_err | output | 1 | Character-code write dropped as out of range |

## Verification
The bench probes the edges of the counter and the range windows.

- **Counter wrap.** It steps the pattern target past 0x3F and below 0, and steps the character target from 0x7F. A design that uses the wrong wrap width shows up with a pattern address above 63 or a character address stuck at 0x80.
- **Range windows.** It writes at 0x27/0x28, 0x40, 0x67/0x68 and 0x4F/0x50 in both line modes. An off-by-one bound, or a window taken from the wrong mode, either strobes a forbidden address or flags a legal one.
- **Busy timing.** It counts the oscillator ticks that busy covers. It also fires a write while busy and then reads bytes and unused codes. A design that counts one tick too many or too few, or accepts during busy, ends up with a moved counter or a stray strobe.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    localparam int AC_W     = 7;
    localparam int PAT_W    = 6;
    localparam int ATTR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int NUM_TGT  = 3;

    localparam logic [AC_W-1:0] ONE_LINE_LAST = 7'h4F;
    localparam logic [AC_W-1:0] ROW0_LAST     = 7'h27;
    localparam logic [AC_W-1:0] ROW1_FIRST    = 7'h40;
    localparam logic [AC_W-1:0] ROW1_LAST     = 7'h67;

    typedef enum logic [1:0] {
        TGT_CHAR = 2'd0,
        TGT_PAT  = 2'd1,
        TGT_ATTR = 2'd2
    } target_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_CHAR,
        OP_SET_PAT,
        OP_SET_ATTR,
        OP_WRITE
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [AC_W-1:0]   addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic cmd_t decode_cmd(logic [1:0] rs, logic rw,
                                        logic [DATA_W-1:0] d);
        cmd_t c;
        c.op   = OP_NONE;
        c.addr = '0;
        c.data = d;
        if (!rw && rs == 2'b10) begin
            if (d[7]) begin
                c.op   = OP_SET_CHAR;
                c.addr = d[AC_W-1:0];
            end else if (d[6]) begin
                c.op   = OP_SET_PAT;
                c.addr = {{(AC_W-PAT_W){1'b0}}, d[PAT_W-1:0]};
            end else if (d[5]) begin
                c.op   = OP_SET_ATTR;
                c.addr = {{(AC_W-ATTR_W){1'b0}}, d[ATTR_W-1:0]};
            end
        end else if (!rw && rs == 2'b11) begin
            c.op = OP_WRITE;
        end
        return c;
    endfunction

    function automatic logic char_addr_ok(logic [AC_W-1:0] a, logic two_ln);
        if (two_ln)
            return (a <= ROW0_LAST) || (a >= ROW1_FIRST && a <= ROW1_LAST);
        return a <= ONE_LINE_LAST;
    endfunction

    function automatic logic [AC_W-1:0] step_addr(logic [AC_W-1:0] a,
                                                  logic up, target_e t);
        logic [AC_W-1:0] n;
        n = up ? a + 1'b1 : a - 1'b1;
        if (t == TGT_PAT)
            n = {{(AC_W-PAT_W){1'b0}}, n[PAT_W-1:0]};
        return n;
    endfunction

endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
    import chardisp_pkg::*;
(
    input  logic              host_we,
    input  logic [1:0]        host_rs,
    input  logic              host_rw,
    input  logic [DATA_W-1:0] host_data,
    input  logic              busy,
    output cmd_t              cmd,
    output logic              accept
);

    always_comb begin
        cmd    = decode_cmd(host_rs, host_rw, host_data);
        accept = host_we && !busy && (cmd.op != OP_NONE);
    end

endmodule

// File: rtl/chardisp_addr_ctr.sv
module chardisp_addr_ctr
    import chardisp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  cmd_t            cmd,
    input  logic            entry_inc,
    input  logic            two_line,
    output logic [AC_W-1:0] ac,
    output target_e         target,
    output logic            range_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ac     <= '0;
            target <= TGT_CHAR;
        end else if (accept) begin
            unique case (cmd.op)
                OP_SET_CHAR: begin ac <= cmd.addr; target <= TGT_CHAR; end
                OP_SET_PAT:  begin ac <= cmd.addr; target <= TGT_PAT;  end
                OP_SET_ATTR: begin ac <= cmd.addr; target <= TGT_ATTR; end
                OP_WRITE:    ac <= step_addr(ac, entry_inc, target);
                default:     ;
            endcase
        end
    end

    always_comb range_err = (target == TGT_CHAR) && !char_addr_ok(ac, two_line);

    // R3: a pattern-targeted counter never reaches the upper half
    a_r3_pat_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (target == TGT_PAT) |-> (ac[AC_W-1] == 1'b0));

    // R6: data writes leave the target alone
    a_r6_target_sticky: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd.op == OP_WRITE) |=> $stable(target));

    // R7: an accepted write always moves the counter
    a_r7_write_steps: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd.op == OP_WRITE) |=> (ac != $past(ac)));

endmodule

// File: rtl/chardisp_busy_timer.sv
module chardisp_busy_timer #(
    parameter int BUSY_TICKS = 10,
    localparam int CNT_W = $clog2(BUSY_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic osc_tick,
    output logic busy
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CNT_W'(BUSY_TICKS);
        end else if (busy && osc_tick) begin
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1))
                busy <= 1'b0;
        end
    end

    // R11: an accepted command always raises busy
    a_r11_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R12: no command is started while one is executing
    a_r12_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

    // R11: busy only drops on an oscillator tick
    a_r11_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && !osc_tick && !start) |=> busy);

endmodule

// File: rtl/chardisp_wr_port.sv
module chardisp_wr_port
    import chardisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  target_e           target,
    input  logic [AC_W-1:0]   ac,
    input  logic [DATA_W-1:0] data,
    input  logic              range_err,
    output logic [NUM_TGT-1:0] we,
    output logic [AC_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              addr_err
);

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_strobe
        localparam target_e TG = target_e'(g);
        logic blocked;
        if (TG == TGT_CHAR) begin : g_chk
            assign blocked = range_err;
        end else begin : g_free
            assign blocked = 1'b0;
        end
        always_ff @(posedge clk) begin
            if (rst) we[g] <= 1'b0;
            else     we[g] <= fire && (target == TG) && !blocked;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            mem_data <= '0;
            addr_err <= 1'b0;
        end else begin
            addr_err <= fire && range_err;
            if (fire) begin
                mem_addr <= ac;
                mem_data <= data;
            end
        end
    end

    // R5: at most one memory strobed per cycle
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we));

    // R9: a flagged write never reaches the character memory
    a_r9_err_blocks_write: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> !we[0]);

    // R5: strobes last a single cycle
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (we != '0) |=> (we == '0));

endmodule

// File: rtl/chardisp_cmd_decoder.sv
module chardisp_cmd_decoder
    import chardisp_pkg::*;
#(
    parameter int BUSY_TICKS = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_tick,
    input  logic        host_we,
    input  logic [1:0]  host_rs,
    input  logic        host_rw,
    input  logic [7:0]  host_data,
    input  logic        entry_inc,
    input  logic        two_line,
    output logic        busy,
    output logic [6:0]  addr_count,
    output logic [1:0]  target_sel,
    output logic        chr_we,
    output logic        pat_we,
    output logic        atr_we,
    output logic [6:0]  mem_addr,
    output logic [7:0]  mem_data,
    output logic        addr_err
);

    cmd_t               cmd;
    logic               accept;
    logic [AC_W-1:0]    ac;
    target_e            target;
    logic               range_err;
    logic [NUM_TGT-1:0] we;
    logic               fire;

    chardisp_decode u_decode (
        .host_we   (host_we),
        .host_rs   (host_rs),
        .host_rw   (host_rw),
        .host_data (host_data),
        .busy      (busy),
        .cmd       (cmd),
        .accept    (accept)
    );

    chardisp_addr_ctr u_addr_ctr (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .cmd       (cmd),
        .entry_inc (entry_inc),
        .two_line  (two_line),
        .ac        (ac),
        .target    (target),
        .range_err (range_err)
    );

    chardisp_busy_timer #(.BUSY_TICKS(BUSY_TICKS)) u_busy (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .osc_tick (osc_tick),
        .busy     (busy)
    );

    assign fire = accept && (cmd.op == OP_WRITE);

    chardisp_wr_port u_wr_port (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .target    (target),
        .ac        (ac),
        .data      (cmd.data),
        .range_err (range_err),
        .we        (we),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .addr_err  (addr_err)
    );

    assign addr_count = ac;
    assign target_sel = target;
    assign chr_we     = we[TGT_CHAR];
    assign pat_we     = we[TGT_PAT];
    assign atr_we     = we[TGT_ATTR];

    // R12: a strobe during busy never reaches a memory
    a_r12_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && host_we) |=> !(chr_we || pat_we || atr_we || addr_err));

    // R12: a strobe during busy leaves the counter alone
    a_r12_hold_counter: assert property (@(posedge clk) disable iff (rst)
        (busy && host_we) |=> $stable(addr_count));

endmodule

// File: tb/chardisp_cmd_decoder_bench.sv
module chardisp_cmd_decoder_bench;

    localparam int BUSY_TICKS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       host_we = 1'b0;
    logic [1:0] host_rs = 2'b00;
    logic       host_rw = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       entry_inc = 1'b1;
    logic       two_line = 1'b0;
    logic       busy;
    logic [6:0] addr_count;
    logic [1:0] target_sel;
    logic       chr_we, pat_we, atr_we;
    logic [6:0] mem_addr;
    logic [7:0] mem_data;
    logic       addr_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    chardisp_cmd_decoder #(.BUSY_TICKS(BUSY_TICKS)) u_chardisp_cmd_decoder (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .host_we(host_we),
        .host_rs(host_rs), .host_rw(host_rw), .host_data(host_data),
        .entry_inc(entry_inc), .two_line(two_line), .busy(busy),
        .addr_count(addr_count), .target_sel(target_sel), .chr_we(chr_we),
        .pat_we(pat_we), .atr_we(atr_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .addr_err(addr_err)
    );

    always #4 clk = ~clk;

    initial begin
        int div;
        div = 0;
        forever begin
            @(posedge clk);
            #2;
            div = (div == 2) ? 0 : div + 1;
            osc_tick = (div == 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                finish_run();
            end
        end
    end

    task automatic do_cmd(input logic [1:0] rs, input logic rw, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_rs = rs; host_rw = rw; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic set_addr(input logic [7:0] code);
        do_cmd(2'b10, 1'b0, code);
        wait_idle();
    endtask

    // one data write; tgt: 0 char, 1 pattern, 2 attribute
    task automatic wr(input logic [7:0] d, input int tgt, input logic [6:0] exp_addr,
                      input bit exp_err, input logic [6:0] exp_next, input string tag);
        logic [2:0] exp_we;
        do_cmd(2'b11, 1'b0, d);
        exp_we = exp_err ? 3'b000 : (3'b001 << tgt);
        chk({atr_we, pat_we, chr_we} == exp_we, {tag, " strobe"}, {atr_we, pat_we, chr_we}, exp_we);
        chk(addr_err == exp_err, {tag, " addr_err"}, addr_err, exp_err);
        if (!exp_err) begin
            chk(mem_addr == exp_addr, {tag, " mem_addr"}, mem_addr, exp_addr);
            chk(mem_data == d, {tag, " mem_data"}, mem_data, d);
        end
        chk(addr_count == exp_next, {tag, " counter step"}, addr_count, exp_next);
        @(negedge clk);
        chk({atr_we, pat_we, chr_we, addr_err} == 4'b0, {tag, " R5 single-cycle"},
            {atr_we, pat_we, chr_we, addr_err}, 0);
        wait_idle();
    endtask

    task automatic t_reset();
        chk(addr_count == 7'h00, "R1 counter", addr_count, 0);
        chk(target_sel == 2'd0, "R1 target", target_sel, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk({chr_we, pat_we, atr_we, addr_err} == 4'b0, "R1 strobes",
            {chr_we, pat_we, atr_we, addr_err}, 0);
    endtask

    task automatic t_char_inc_dec();
        two_line = 1'b0; entry_inc = 1'b1;
        set_addr(8'h85);
        chk(addr_count == 7'h05, "R2 load", addr_count, 5);
        chk(target_sel == 2'd0, "R2 target", target_sel, 0);
        wr(8'hA1, 0, 7'h05, 0, 7'h06, "R5 R7 char inc");
        wr(8'hA2, 0, 7'h06, 0, 7'h07, "R6 char sticky");
        entry_inc = 1'b0;
        wr(8'hA3, 0, 7'h07, 0, 7'h06, "R7 char dec");
    endtask

    task automatic t_pattern();
        entry_inc = 1'b1;
        set_addr(8'h7F);
        chk(addr_count == 7'h3F, "R3 load", addr_count, 7'h3F);
        chk(target_sel == 2'd1, "R3 target", target_sel, 1);
        wr(8'h11, 1, 7'h3F, 0, 7'h00, "R8 pattern wrap up");
        entry_inc = 1'b0;
        wr(8'h22, 1, 7'h00, 0, 7'h3F, "R8 pattern wrap down");
        chk(target_sel == 2'd1, "R6 pattern sticky", target_sel, 1);
    endtask

    task automatic t_attr();
        entry_inc = 1'b0;
        set_addr(8'h3F);
        chk(addr_count == 7'h1F, "R4 load", addr_count, 7'h1F);
        chk(target_sel == 2'd2, "R4 target", target_sel, 2);
        set_addr(8'h20);
        wr(8'h5A, 2, 7'h00, 0, 7'h7F, "R8 attr wrap 7-bit");
        entry_inc = 1'b1;
        wr(8'h5B, 2, 7'h7F, 0, 7'h00, "R8 attr wrap up");
    endtask

    task automatic t_char_wrap();
        entry_inc = 1'b1; two_line = 1'b1;
        set_addr(8'hFF);
        chk(addr_count == 7'h7F, "R2 load high", addr_count, 7'h7F);
        wr(8'h33, 0, 7'h7F, 1, 7'h00, "R8 R10 char wrap with error");
    endtask

    task automatic t_one_line();
        two_line = 1'b0; entry_inc = 1'b1;
        set_addr(8'hCF);
        wr(8'h41, 0, 7'h4F, 0, 7'h50, "R9 last legal 0x4F");
        wr(8'h42, 0, 7'h50, 1, 7'h51, "R9 first illegal 0x50");
        set_addr(8'hB0);
        wr(8'h43, 0, 7'h30, 0, 7'h31, "R9 0x30 legal in one-line");
    endtask

    task automatic t_two_line();
        two_line = 1'b1; entry_inc = 1'b1;
        set_addr(8'hA7);
        wr(8'h51, 0, 7'h27, 0, 7'h28, "R10 0x27 legal");
        wr(8'h52, 0, 7'h28, 1, 7'h29, "R10 0x28 illegal");
        set_addr(8'hB0);
        wr(8'h53, 0, 7'h30, 1, 7'h31, "R10 0x30 illegal");
        set_addr(8'hC0);
        wr(8'h54, 0, 7'h40, 0, 7'h41, "R10 0x40 legal");
        set_addr(8'hE7);
        wr(8'h55, 0, 7'h67, 0, 7'h68, "R10 0x67 legal");
        wr(8'h56, 0, 7'h68, 1, 7'h69, "R10 0x68 illegal");
        set_addr(8'hCF);
        wr(8'h57, 0, 7'h4F, 0, 7'h50, "R10 0x4F legal in two-line");
    endtask

    task automatic t_busy();
        int n;
        two_line = 1'b0; entry_inc = 1'b1;
        do_cmd(2'b10, 1'b0, 8'h90);
        chk(busy == 1'b1, "R11 busy rises", busy, 1);
        n = 0;
        while (busy) begin
            if (osc_tick) n++;
            @(negedge clk);
        end
        chk(n == BUSY_TICKS, "R11 tick count", n, BUSY_TICKS);
        do_cmd(2'b10, 1'b0, 8'h88);
        do_cmd(2'b11, 1'b0, 8'h77);
        chk({chr_we, pat_we, atr_we, addr_err} == 4'b0, "R12 write while busy strobe",
            {chr_we, pat_we, atr_we, addr_err}, 0);
        chk(addr_count == 7'h08, "R12 counter held", addr_count, 8);
        do_cmd(2'b10, 1'b0, 8'h45);
        chk(target_sel == 2'd0 && addr_count == 7'h08, "R12 set while busy",
            {target_sel, addr_count}, {2'd0, 7'h08});
        wait_idle();
        wr(8'h78, 0, 7'h08, 0, 7'h09, "R12 next write after busy");
    endtask

    task automatic t_ignored();
        set_addr(8'h45);
        chk(addr_count == 7'h05 && target_sel == 2'd1, "R3 setup",
            {target_sel, addr_count}, {2'd1, 7'h05});
        do_cmd(2'b11, 1'b1, 8'h99);
        chk(busy == 1'b0 && pat_we == 1'b0, "R13 read ignored", {busy, pat_we}, 0);
        do_cmd(2'b00, 1'b0, 8'h81);
        chk(busy == 1'b0 && addr_count == 7'h05, "R13 rs 00 ignored",
            {busy, addr_count}, 7'h05);
        do_cmd(2'b01, 1'b0, 8'h81);
        chk(busy == 1'b0 && addr_count == 7'h05, "R13 rs 01 ignored",
            {busy, addr_count}, 7'h05);
        do_cmd(2'b10, 1'b0, 8'h1F);
        chk(busy == 1'b0 && addr_count == 7'h05 && target_sel == 2'd1,
            "R13 unused set code ignored", {busy, target_sel, addr_count}, {2'd1, 7'h05});
        do_cmd(2'b10, 1'b1, 8'h81);
        chk(busy == 1'b0 && target_sel == 2'd1, "R13 read on rs 10 ignored",
            {busy, target_sel}, 1);
        wr(8'h66, 1, 7'h05, 0, 7'h06, "R13 state intact");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_char_inc_dec();
        t_pattern();
        t_attr();
        t_char_wrap();
        t_one_line();
        t_two_line();
        t_busy();
        t_ignored();
        finish_run();
    end

endmodule